// File: doc/BRIEF.md
# Parallel Flash Bus Front End

This block is the clocked front end behind an asynchronous parallel flash-style bus. It takes three active-low strobes (chip enable, write enable, output enable), an address bus, a flag that reports a high voltage on address bit 9, and the two halves of an 8-bit bidirectional data pad. It synchronizes the strobes and rejects short pulses on them. From the filtered strobes it reports which bus operation is in progress.

On a write it captures the address at the later of the two falling enables. It captures the data at the earlier of the two rising enables. It then hands both to a downstream command interpreter as a one-cycle pulse. On a read it presents the synchronized address to the array and drives the array's byte onto the pad. When the identification mode is selected, it drives the manufacturer code or the device code instead.

An inactivity counter raises a standby flag once strobes and address have been quiet long enough. The flag has no effect on a read in progress. The address and data are delayed through a pipeline that matches the strobe path. As a result, every capture sees the bus as it stood when the strobe edge was first sampled.

Top module: `flash_bus_frontend`

## Requirements
- R1: `bus_op` reports the filtered strobe state with this encoding: 0 when chip enable is high (standby); 2 when chip enable and write enable are both low (write); 1 when chip enable and output enable are low and write enable is high (read); 3 when chip enable is low and the other two are high (output disable). It reflects a strobe change FILT+2 clock edges after that change, where FILT = ceil(5 ns / clock period), which is 2 at a 4 ns clock.
- R2: `dq_oe` is high only in the read state. It is low whenever output enable or chip enable is high, whatever the state of the other strobes.
- R3: A pulse on any strobe that lasts fewer than FILT clock cycles has no effect on `bus_op`, `dq_oe` or `wr_valid`. A pulse of exactly FILT cycles is accepted.
- R4: `wr_addr` takes the address present when the later of chip enable and write enable goes low. This holds for either order of the two falling edges.
- R5: `wr_data` takes the data pad value present when the earlier of chip enable and write enable goes high. This holds for either order of the two rising edges.
- R6: `wr_valid` is a single-cycle pulse FILT+2 edges after the earlier rising enable of a write. `wr_addr` and `wr_data` hold their values until the next accepted write.
- R7: A write during which output enable is low at any point produces no `wr_valid`, and `wr_data` keeps its previous value.
- R8: `rd_addr` follows `addr` with a latency of FILT+1 edges. `dq_out` carries `rd_data` for that address one edge later.
- R9: When the ID flag is high and address bit 1 is low, `dq_out` is 20h for address bit 0 low and DEV_CODE (default B0h) for address bit 0 high. Otherwise it carries `rd_data`.
- R10: `standby` rises once strobes, ID flag and address have stayed unchanged for IDLE = ceil(150 ns / clock period) cycles, which is 38 at 4 ns. For an address change, it falls FILT+2 edges after the change and rises again FILT+2+IDLE edges after it.
- R11: `standby` does not affect a read in progress: `dq_oe` and `dq_out` keep serving the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable from the bus, active low |
| we_n | input | 1 | Write enable from the bus, active low |
| oe_n | input | 1 | Output enable from the bus, active low |
| addr | input | AW | Bus address |
| id_hv | input | 1 | High-voltage detect on address bit 9 |
| dq_in | input | 8 | Data pad input |
| dq_out | output | 8 | Data pad output value |
| dq_oe | output | 1 | Data pad output enable |
| rd_addr | output | AW | Synchronized address to the array |
| rd_data | input | 8 | Array byte for `rd_addr`, combinational |
| bus_op | output | 2 | Current bus operation |
| standby | output | 1 | Automatic standby flag |
| wr_valid | output | 1 | One-cycle write completion pulse |
| wr_addr | output | AW | Captured write address |
| wr_data | output | 8 | Captured write data |

## Verification
The bench drives every input half a cycle away from the sampling edge and counts edges from there. It samples `bus_op`, `dq_oe` and `wr_valid` exactly FILT+2 edges after the strobe change. It also samples them one edge earlier to confirm that they have not yet moved. `rd_addr` is checked FILT+1 edges after an address change and `dq_out` one edge later. The standby edges are checked at their exact cycles after an address change. Write pulses are also counted by a monitor that runs away from the edge. Rejected writes and rejected glitches are therefore seen as a missing pulse, in addition to the sampled check.

// File: rtl/flash_bus_frontend.sv
module flash_bus_frontend #(
  parameter int AW = 18,
  parameter int CLK_PS = 4000,
  parameter int GLITCH_PS = 5000,
  parameter int IDLE_PS = 150000,
  parameter logic [7:0] MFR_CODE = 8'h20,
  parameter logic [7:0] DEV_CODE = 8'hB0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic          id_hv,
  input  logic [7:0]    dq_in,
  output logic [7:0]    dq_out,
  output logic          dq_oe,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic [1:0]    bus_op,
  output logic          standby,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data
);
  localparam int FILT_RAW = (GLITCH_PS + CLK_PS - 1) / CLK_PS;
  localparam int FILT = (FILT_RAW < 1) ? 1 : FILT_RAW;
  localparam int IDLE_RAW = (IDLE_PS + CLK_PS - 1) / CLK_PS;
  localparam int IDLE = (IDLE_RAW < 1) ? 1 : IDLE_RAW;
  localparam int FCW = (FILT < 2) ? 1 : $clog2(FILT);
  localparam int CW = $clog2(IDLE + 1);
  localparam int PW = AW + 9;
  localparam int SW = AW + 4;
  localparam logic [1:0] OP_STBY = 2'd0;
  localparam logic [1:0] OP_READ = 2'd1;
  localparam logic [1:0] OP_WRITE = 2'd2;
  localparam logic [1:0] OP_ODIS = 2'd3;

  // strobe bit order: 0 chip enable, 1 write enable, 2 output enable
  logic [2:0] s1, s2, f, f_nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 3'b111;
      s2 <= 3'b111;
    end else begin
      s1 <= {oe_n, we_n, ce_n};
      s2 <= s1;
    end

  for (genvar g = 0; g < 3; g++) begin : g_filt
    logic [FCW-1:0] cnt;
    logic fr, hit;
    assign hit = (s2[g] != fr) && (cnt == FCW'(FILT - 1));
    assign f_nxt[g] = hit ? s2[g] : fr;
    assign f[g] = fr;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        fr <= 1'b1;
        cnt <= '0;
      end else begin
        fr <= f_nxt[g];
        if (s2[g] == fr || hit) cnt <= '0;
        else cnt <= cnt + 1'b1;
      end
  end

  logic [PW-1:0] pipe [FILT+1];
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i <= FILT; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= {id_hv, addr, dq_in};
      for (int i = 1; i <= FILT; i++) pipe[i] <= pipe[i-1];
    end

  logic          p_hv;
  logic [AW-1:0] p_addr;
  logic [7:0]    p_dq;
  assign {p_hv, p_addr, p_dq} = pipe[FILT];
  assign rd_addr = p_addr;

  logic wa, wa_n, wbad;
  assign wa   = !f[0] && !f[1];
  assign wa_n = !f_nxt[0] && !f_nxt[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      wbad <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      if (wa_n && !wa) begin
        wr_addr <= p_addr;
        wbad <= !f_nxt[2];
      end else if (wa_n && !f_nxt[2]) begin
        wbad <= 1'b1;
      end
      if (!wa_n && wa && !wbad && f_nxt[2]) begin
        wr_valid <= 1'b1;
        wr_data <= p_dq;
      end
    end

  always_comb begin
    if (f[0])       bus_op = OP_STBY;
    else if (!f[1]) bus_op = OP_WRITE;
    else if (!f[2]) bus_op = OP_READ;
    else            bus_op = OP_ODIS;
  end
  assign dq_oe = !f[0] && !f[2] && f[1];

  logic id_sel;
  assign id_sel = p_hv && !p_addr[1];
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dq_out <= '0;
    else dq_out <= id_sel ? (p_addr[0] ? DEV_CODE : MFR_CODE) : rd_data;

  logic [SW-1:0] snap, prev;
  logic [CW-1:0] idle_cnt;
  assign snap = {f, p_hv, p_addr};
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev <= {3'b111, 1'b0, {AW{1'b0}}};
      idle_cnt <= '0;
    end else begin
      prev <= snap;
      if (snap != prev) idle_cnt <= '0;
      else if (idle_cnt != CW'(IDLE)) idle_cnt <= idle_cnt + 1'b1;
    end
  assign standby = (idle_cnt == CW'(IDLE));
endmodule

// File: rtl/flash_bus_frontend_chk.sv
module flash_bus_frontend_chk #(
  parameter int AW = 18,
  parameter logic [7:0] MFR_CODE = 8'h20,
  parameter logic [7:0] DEV_CODE = 8'hB0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dq_oe,
  input logic          wr_valid,
  input logic          standby,
  input logic [AW-1:0] rd_addr,
  input logic [7:0]    dq_out,
  input logic          id_q
);
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  assert_no_drive_in_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !$past(dq_oe));

  assert_idle_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_addr) |=> !standby);

  assert_mfr_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (id_q && rd_addr[1:0] == 2'b00) |=> dq_out == MFR_CODE);

  assert_dev_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (id_q && rd_addr[1:0] == 2'b01) |=> dq_out == DEV_CODE);
endmodule

bind flash_bus_frontend flash_bus_frontend_chk #(
  .AW(AW), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dq_oe(dq_oe), .wr_valid(wr_valid),
  .standby(standby), .rd_addr(rd_addr), .dq_out(dq_out), .id_q(p_hv)
);

// File: tb/test_flash_bus_frontend.sv
`timescale 1ns/1ps
module test_flash_bus_frontend;
  localparam int AW = 18;
  localparam int FILT = 2;
  localparam int LAT = FILT + 2;
  localparam int IDLE = 38;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, ce_n, we_n, oe_n, id_hv;
  logic [AW-1:0] addr, rd_addr, wr_addr;
  logic [7:0] dq_in, dq_out, rd_data, wr_data;
  logic dq_oe, standby, wr_valid;
  logic [1:0] bus_op;

  function automatic logic [7:0] model(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction
  assign rd_data = model(rd_addr);

  flash_bus_frontend i_flash_bus_frontend (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .id_hv(id_hv), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .rd_addr(rd_addr), .rd_data(rd_data), .bus_op(bus_op), .standby(standby),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int tests = 0, fails = 0, pulses = 0;
  bit done = 0;
  logic [7:0] last_d = 8'h00;

  always @(posedge clk) begin
    #1;
    if (wr_valid) pulses++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d,
                          input bit ce_fall_first, input bit ce_rise_first, input bit oe_bad);
    int p0 = pulses;
    addr = a ^ 18'h3FFFF; dq_in = ~d;
    if (ce_fall_first) ce_n = 0; else we_n = 0;
    step(4);
    addr = a;
    if (ce_fall_first) we_n = 0; else ce_n = 0;
    step(1);
    addr = a ^ 18'h15555;
    step(4);
    if (oe_bad) begin oe_n = 0; step(3); oe_n = 1; step(1); end
    dq_in = d;
    if (ce_rise_first) ce_n = 1; else we_n = 1;
    step(1);
    dq_in = ~d;
    step(LAT - 2);
    chk(wr_valid == 0, "R6 early", wr_valid, 0);
    step(1);
    chk(wr_valid == !oe_bad, oe_bad ? "R7 pulse" : "R6 pulse", wr_valid, !oe_bad);
    if (!oe_bad) begin
      chk(wr_addr == a, "R4 addr", wr_addr, a);
      chk(wr_data == d, "R5 data", wr_data, d);
      last_d = d;
    end else begin
      chk(wr_data == last_d, "R7 data kept", wr_data, last_d);
    end
    step(1);
    chk(wr_valid == 0, "R6 single", wr_valid, 0);
    ce_n = 1; we_n = 1;
    step(LAT + 2);
    chk(pulses - p0 == (oe_bad ? 0 : 1), "R7 count", pulses - p0, oe_bad ? 0 : 1);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ce_n = 1; we_n = 1; oe_n = 1; id_hv = 0; addr = '0; dq_in = '0;
    step(3);
    chk(bus_op == 0, "R1 reset", bus_op, 0);
    chk(dq_oe == 0 && wr_valid == 0 && standby == 0, "R2 reset", {dq_oe, wr_valid, standby}, 0);
    rst_n = 1;
    step(LAT + 2);

    // R1, R2: all strobe combinations
    for (int k = 0; k < 8; k++) begin
      int eop, eoe;
      ce_n = k[0]; we_n = k[1]; oe_n = k[2];
      eop = k[0] ? 0 : (!k[1] ? 2 : (!k[2] ? 1 : 3));
      eoe = (!k[0] && !k[2] && k[1]) ? 1 : 0;
      step(LAT - 1);
      chk(bus_op == 0 && dq_oe == 0, "R1 latency", bus_op, 0);
      step(1);
      chk(bus_op == eop, "R1 op", bus_op, eop);
      chk(dq_oe == eoe, "R2 oe", dq_oe, eoe);
      ce_n = 1; we_n = 1; oe_n = 1;
      step(LAT + 2);
    end

    // R8: read sweep
    ce_n = 0; oe_n = 0; we_n = 1;
    for (int i = 0; i < 64; i++) begin
      logic [AW-1:0] a;
      a = AW'((i * 4099 + 17) & 18'h3FFFF);
      addr = a;
      step(LAT - 1);
      chk(rd_addr == a, "R8 rd_addr", rd_addr, a);
      step(1);
      chk(dq_out == model(a) && dq_oe, "R8 dq_out", dq_out, model(a));
    end

    // R9: identification codes
    for (int hv = 0; hv < 2; hv++) begin
      for (int lo = 0; lo < 4; lo++) begin
        logic [AW-1:0] a;
        logic [7:0] e;
        a = 18'h2A5C0 | AW'(lo);
        id_hv = hv[0]; addr = a;
        e = (hv == 1 && lo < 2) ? ((lo == 1) ? 8'hB0 : 8'h20) : model(a);
        step(LAT);
        chk(dq_out == e, "R9 id", dq_out, e);
      end
    end

    // R11, R10
    id_hv = 0; addr = 18'h01234;
    step(LAT + IDLE + 4);
    chk(standby == 1, "R10 enter", standby, 1);
    chk(dq_oe == 1 && dq_out == model(18'h01234), "R11 read kept", dq_out, model(18'h01234));
    addr = 18'h04321;
    step(LAT - 1);
    chk(standby == 1, "R10 before restart", standby, 1);
    step(1);
    chk(standby == 0, "R10 restart", standby, 0);
    step(IDLE - 1);
    chk(standby == 0, "R10 not yet", standby, 0);
    step(1);
    chk(standby == 1, "R10 exact", standby, 1);
    ce_n = 1; oe_n = 1;
    step(LAT + 2);

    // R4, R5, R6, R7: writes in all edge orders
    for (int o = 0; o < 4; o++) begin
      for (int v = 0; v < 3; v++) begin
        do_write(AW'(18'h0A5A5 + o * 18'h01111 + v * 18'h10203), 8'(8'h11 * (o + 1) + v * 8'h35),
                 o[0], o[1], 1'b0);
      end
      do_write(AW'(18'h3C3C3 - o), 8'(8'hE7 - o), o[0], o[1], 1'b1);
    end

    // R3: glitch rejection
    begin
      int p0;
      bit ok;
      ce_n = 0; oe_n = 1; we_n = 1; addr = 18'h00777; dq_in = 8'h99;
      step(LAT + 2);
      p0 = pulses; ok = 1;
      we_n = 0; step(1); we_n = 1;
      for (int i = 0; i < LAT + 4; i++) begin
        step(1);
        if (bus_op != 3) ok = 0;
      end
      chk(ok, "R3 short we", bus_op, 3);
      chk(pulses == p0, "R3 short we pulse", pulses - p0, 0);
      we_n = 0; step(FILT); we_n = 1;
      step(LAT + 4);
      chk(pulses == p0 + 1, "R3 min pulse", pulses - p0, 1);
      chk(wr_addr == 18'h00777 && wr_data == 8'h99, "R3 min pulse capture", wr_addr, 18'h00777);
      ce_n = 1; oe_n = 0;
      step(LAT + 2);
      ok = 1;
      ce_n = 0; step(1); ce_n = 1;
      for (int i = 0; i < LAT + 4; i++) begin
        step(1);
        if (dq_oe != 0 || bus_op != 0) ok = 0;
      end
      chk(ok, "R3 short ce", dq_oe, 0);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule